// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is a bank of general-purpose pins behind a simple word-wide register port. Software programs each pin as an output or an input. It can move a pin's value or direction without a read-modify-write by using separate set and clear addresses. On an input pin, the same value bit selects a weak pull-up or pull-down, unless pulls are switched off for that pin. A per-pin select hands the pad to an alternate-function source supplied at the ports.

Input pads are brought into the clock domain through a synchroniser chain before they are read back or used for edge detection. Each pin has its own rising-edge enable and falling-edge enable. A detected edge latches a sticky pending bit, and software clears it by writing ones. A single interrupt line is high while any pending bit is set. Only edges raise interrupts, never levels.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the value, direction, pull-off, alternate-select, both edge-enable and pending registers read zero, `irq` is low, `pad_oe` and `pad_pu` are all zero and `pad_pd` is all ones.
- R2: A write to byte offset 0x00 loads the value register. A write to 0x04 ORs the written ones into it and a write to 0x08 clears the written ones. Bits written as zero are left unchanged.
- R3: Direction lives at 0x10, with OR-alias 0x14 and clear-alias 0x18. A direction bit of 1 drives `pad_oe` high and `pad_out` with the value bit, and a bit of 0 leaves the pin undriven with `pad_out` low.
- R4: On a non-alternate input pin whose pull-off bit (offset 0x0C) is 0, a value bit of 1 asserts `pad_pu` and 0 asserts `pad_pd`. A pull-off bit of 1, or an output pin, asserts neither pull.
- R5: A 1 in the alternate-select register (0x20) routes `alt_oe`/`alt_out` of that pin to `pad_oe`/`pad_out` and disables both pulls.
- R6: Reading 0x00 returns the value register on output pins and the synchronised pad level on input pins. A pad change becomes visible after SYNC_STAGES rising clock edges.
- R7: A rising edge on a pin whose rising-enable bit (0x40) is 1, or a falling edge on a pin whose falling-enable bit (0x44) is 1, sets that pin's pending bit (read at 0x48) one clock after the synchronised level changes. Edges that are not enabled, and steady levels, set nothing.
- R8: Writing ones to 0x4C clears those pending bits, and all ones clears every bit. A write to 0x48 has no effect.
- R9: When an enabled edge and a clear of the same pending bit arrive in the same cycle, the bit stays set.
- R10: `irq` is high exactly while at least one pending bit is set.
- R11: Reads of 0x04, 0x08, 0x14, 0x18, 0x4C and of any unmapped offset return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| alt_oe | input | NPINS | Output enable from the alternate-function source |
| alt_out | input | NPINS | Output value from the alternate-function source |
| pad_oe | output | NPINS | Pad output enable |
| pad_out | output | NPINS | Pad output value |
| pad_pu | output | NPINS | Pad pull-up enable |
| pad_pd | output | NPINS | Pad pull-down enable |
| irq | output | 1 | Interrupt, high while any pending bit is set |

## Verification
The bench builds the bank at full width (NPINS = 32) with the default two-stage synchroniser and a 12-bit window address. At this width, bit 31 and all-ones masks reach the top of the register word, and a clear of every pending bit is a real boundary case. With two stages, the bench can pin down the exact cycle in which a pad change shows up in the readback and in which the pending bit and `irq` rise. The collision of an edge with a clear in one cycle is forced deliberately.

// File: rtl/gpb_pkg.sv
`timescale 1ns/1ps
package gpb_pkg;
   localparam int unsigned WORD_W = 32;

   // byte offsets inside the bank window; software depends on them
   localparam logic [11:0] OFS_VAL     = 12'h000;
   localparam logic [11:0] OFS_VAL_OR  = 12'h004;
   localparam logic [11:0] OFS_VAL_CLR = 12'h008;
   localparam logic [11:0] OFS_PULLOFF = 12'h00C;
   localparam logic [11:0] OFS_DIR     = 12'h010;
   localparam logic [11:0] OFS_DIR_OR  = 12'h014;
   localparam logic [11:0] OFS_DIR_CLR = 12'h018;
   localparam logic [11:0] OFS_ALTSEL  = 12'h020;
   localparam logic [11:0] OFS_RISE_EN = 12'h040;
   localparam logic [11:0] OFS_FALL_EN = 12'h044;
   localparam logic [11:0] OFS_PEND    = 12'h048;
   localparam logic [11:0] OFS_ACK     = 12'h04C;
endpackage

// File: rtl/gpb_sync.sv
`timescale 1ns/1ps
module gpb_sync #(
   parameter int unsigned N      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] async_in,
   output logic [N-1:0] sync_out
);
   logic [N-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= async_in;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpb_regs.sv
`timescale 1ns/1ps
module gpb_regs
   import gpb_pkg::*;
#(
   parameter int unsigned N      = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   input  logic [N-1:0]      pin_lvl,
   input  logic [N-1:0]      pend,
   output logic [N-1:0]      val_q,
   output logic [N-1:0]      dir_q,
   output logic [N-1:0]      pulloff_q,
   output logic [N-1:0]      alt_q,
   output logic [N-1:0]      rise_en_q,
   output logic [N-1:0]      fall_en_q,
   output logic [N-1:0]      ack
);
   logic [N-1:0] wbits;
   logic [N-1:0] rd_bits;
   logic we, re;

   assign wbits = wdata[N-1:0];
   assign we    = sel & wr;
   assign re    = sel & ~wr;

   function automatic logic at(input logic [ADDR_W-1:0] a, input logic [11:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q     <= '0;
         dir_q     <= '0;
         pulloff_q <= '0;
         alt_q     <= '0;
         rise_en_q <= '0;
         fall_en_q <= '0;
      end else if (we) begin
         if (at(addr, OFS_VAL))          val_q <= wbits;
         else if (at(addr, OFS_VAL_OR))  val_q <= val_q | wbits;
         else if (at(addr, OFS_VAL_CLR)) val_q <= val_q & ~wbits;
         if (at(addr, OFS_DIR))          dir_q <= wbits;
         else if (at(addr, OFS_DIR_OR))  dir_q <= dir_q | wbits;
         else if (at(addr, OFS_DIR_CLR)) dir_q <= dir_q & ~wbits;
         if (at(addr, OFS_PULLOFF)) pulloff_q <= wbits;
         if (at(addr, OFS_ALTSEL))  alt_q     <= wbits;
         if (at(addr, OFS_RISE_EN)) rise_en_q <= wbits;
         if (at(addr, OFS_FALL_EN)) fall_en_q <= wbits;
      end
   end

   assign ack = (we && at(addr, OFS_ACK)) ? wbits : '0;

   always_comb begin
      rd_bits = '0;
      if (re) begin
         if (at(addr, OFS_VAL))          rd_bits = (dir_q & val_q) | (~dir_q & pin_lvl);
         else if (at(addr, OFS_PULLOFF)) rd_bits = pulloff_q;
         else if (at(addr, OFS_DIR))     rd_bits = dir_q;
         else if (at(addr, OFS_ALTSEL))  rd_bits = alt_q;
         else if (at(addr, OFS_RISE_EN)) rd_bits = rise_en_q;
         else if (at(addr, OFS_FALL_EN)) rd_bits = fall_en_q;
         else if (at(addr, OFS_PEND))    rd_bits = pend;
      end
   end
   assign rdata = WORD_W'(rd_bits);

   assert_val_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && at(addr, OFS_VAL_OR)) |=> (val_q == ($past(val_q) | $past(wbits))));
   assert_val_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && at(addr, OFS_VAL_CLR)) |=> (val_q == ($past(val_q) & ~$past(wbits))));
   assert_dir_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && at(addr, OFS_DIR_OR)) |=> (dir_q == ($past(dir_q) | $past(wbits))));
   assert_dir_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && at(addr, OFS_DIR_CLR)) |=> (dir_q == ($past(dir_q) & ~$past(wbits))));
endmodule

// File: rtl/gpb_pad.sv
`timescale 1ns/1ps
module gpb_pad #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] val,
   input  logic [N-1:0] dir,
   input  logic [N-1:0] pulloff,
   input  logic [N-1:0] alt,
   input  logic [N-1:0] alt_oe,
   input  logic [N-1:0] alt_out,
   output logic [N-1:0] pad_oe,
   output logic [N-1:0] pad_out,
   output logic [N-1:0] pad_pu,
   output logic [N-1:0] pad_pd
);
   genvar p;
   generate
      for (p = 0; p < N; p++) begin : g_pin
         logic pull_ok;
         assign pull_ok    = ~alt[p] & ~dir[p] & ~pulloff[p];
         assign pad_oe[p]  = alt[p] ? alt_oe[p]  : dir[p];
         assign pad_out[p] = alt[p] ? alt_out[p] : (dir[p] & val[p]);
         assign pad_pu[p]  = pull_ok & val[p];
         assign pad_pd[p]  = pull_ok & ~val[p];
      end
   endgenerate

   assert_pull_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pu & pad_pd) == '0) && (((pad_pu | pad_pd) & (dir | alt)) == '0));
endmodule

// File: rtl/gpb_edge_irq.sv
`timescale 1ns/1ps
module gpb_edge_irq #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] rise_en,
   input  logic [N-1:0] fall_en,
   input  logic [N-1:0] ack,
   output logic [N-1:0] pend,
   output logic         irq
);
   logic [N-1:0] prev_q, ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   assign ev = (lvl & ~prev_q & rise_en) | (~lvl & prev_q & fall_en);

   // a new event outranks a same-cycle acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~ack) | ev;
   end

   assign irq = |pend;

   assert_event_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev) |=> ((pend & $past(ev)) == $past(ev)));
   assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack & ~ev)) |=> ((pend & $past(ack & ~ev)) == '0));
   assert_collision_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ack & ev)) |=> ((pend & $past(ack & ev)) == $past(ack & ev)));
   assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|ev));
endmodule

// File: rtl/gpio_edge_bank.sv
`timescale 1ns/1ps
module gpio_edge_bank
   import gpb_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   input  logic [NPINS-1:0]  alt_oe,
   input  logic [NPINS-1:0]  alt_out,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_pu,
   output logic [NPINS-1:0]  pad_pd,
   output logic              irq
);
   generate
      if (NPINS < 1 || NPINS > WORD_W) begin : g_bad_width
         $error("NPINS must lie in 1..32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 7 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie in 7..12");
      end
   endgenerate

   logic [NPINS-1:0] lvl, pend, ack;
   logic [NPINS-1:0] val_q, dir_q, pulloff_q, alt_q, rise_en_q, fall_en_q;

   gpb_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(lvl));

   gpb_regs #(.N(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .pin_lvl(lvl), .pend(pend),
      .val_q(val_q), .dir_q(dir_q), .pulloff_q(pulloff_q), .alt_q(alt_q),
      .rise_en_q(rise_en_q), .fall_en_q(fall_en_q), .ack(ack));

   gpb_pad #(.N(NPINS)) u_pad (
      .clk(clk), .rst_n(rst_n), .val(val_q), .dir(dir_q), .pulloff(pulloff_q),
      .alt(alt_q), .alt_oe(alt_oe), .alt_out(alt_out), .pad_oe(pad_oe),
      .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd));

   gpb_edge_irq #(.N(NPINS)) u_irq (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise_en(rise_en_q),
      .fall_en(fall_en_q), .ack(ack), .pend(pend), .irq(irq));
endmodule

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        bus_sel = 0, bus_wr = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [31:0] pad_in = '0, alt_oe = '0, alt_out = '0;
   logic [31:0] pad_oe, pad_out, pad_pu, pad_pd;
   logic        irq;
   int total = 0, bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_edge_bank #(.NPINS(32), .SYNC_STAGES(2), .ADDR_W(12)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .alt_oe(alt_oe), .alt_out(alt_out), .pad_oe(pad_oe),
      .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic t_reset;
      rdchk("R1 value", 12'h000, 0);
      rdchk("R1 dir", 12'h010, 0);
      rdchk("R1 pulloff", 12'h00C, 0);
      rdchk("R1 altsel", 12'h020, 0);
      rdchk("R1 rise_en", 12'h040, 0);
      rdchk("R1 fall_en", 12'h044, 0);
      rdchk("R1 pending", 12'h048, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 pad_oe", pad_oe, 0);
      chk("R1 pad_pu", pad_pu, 0);
      chk("R1 pad_pd", pad_pd, 32'hFFFF_FFFF);
   endtask

   task automatic t_value;
      wr(12'h010, 32'hFFFF_FFFF);
      wr(12'h000, 32'h0F0F_0000);
      wr(12'h004, 32'h0000_00FF);
      rdchk("R2 or-alias", 12'h000, 32'h0F0F_00FF);
      wr(12'h008, 32'h0F00_0001);
      rdchk("R2 clear-alias", 12'h000, 32'h000F_00FE);
      chk("R3 pad_out all-output", pad_out, 32'h000F_00FE);
      rdchk("R11 read value-or", 12'h004, 0);
      rdchk("R11 read value-clr", 12'h008, 0);
   endtask

   task automatic t_dir;
      wr(12'h010, 32'h0);
      wr(12'h014, 32'h0000_FFFF);
      wr(12'h018, 32'h0000_00F0);
      rdchk("R3 dir", 12'h010, 32'h0000_FF0F);
      chk("R3 pad_oe", pad_oe, 32'h0000_FF0F);
      chk("R3 pad_out", pad_out, 32'h0000_000E);
      rdchk("R6 mixed readback", 12'h000, 32'h0000_000E);
      rdchk("R11 read dir-or", 12'h014, 0);
      rdchk("R11 read dir-clr", 12'h018, 0);
   endtask

   task automatic t_pull;
      wr(12'h010, 32'h0);
      wr(12'h000, 32'h0000_00AA);
      wr(12'h00C, 32'h0000_000F);
      chk("R4 pull-up", pad_pu, 32'h0000_00A0);
      chk("R4 pull-down", pad_pd, 32'hFFFF_FF50);
      wr(12'h010, 32'h0000_00F0);
      chk("R4 output no pull-up", pad_pu, 32'h0);
      chk("R4 output no pull-down", pad_pd, 32'hFFFF_FF00);
      wr(12'h00C, 32'h0);
   endtask

   task automatic t_alt;
      wr(12'h010, 32'hFFFF_FFFF);
      wr(12'h000, 32'h0000_0005);
      alt_oe = 32'h1; alt_out = 32'h3;
      wr(12'h020, 32'h0000_0003);
      chk("R5 pad_oe", pad_oe, 32'hFFFF_FFFD);
      chk("R5 pad_out", pad_out, 32'h0000_0007);
      wr(12'h010, 32'h0);
      wr(12'h000, 32'h0);
      chk("R5 no pulls on alt", pad_pd, 32'hFFFF_FFFC);
      wr(12'h020, 32'h0);
      alt_oe = 0; alt_out = 0;
   endtask

   task automatic t_input;
      wr(12'h010, 32'h0000_FFFF);
      wr(12'h000, 32'h0000_1234);
      pad_in = 32'hABCD_5678;
      repeat (3) @(negedge clk);
      rdchk("R6 input readback", 12'h000, 32'hABCD_1234);
      @(negedge clk); pad_in = 32'h0;
      @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 12'h000;
      #1 chk("R6 one edge later still old", bus_rdata, 32'hABCD_1234);
      @(negedge clk); #1 chk("R6 two edges later new", bus_rdata, 32'h0000_1234);
      bus_sel = 0;
      wr(12'h010, 32'h0);
   endtask

   task automatic t_edges;
      pad_in = 32'h2;
      repeat (4) @(negedge clk);
      wr(12'h040, 32'h1);
      wr(12'h044, 32'h2);
      wr(12'h04C, 32'hFFFF_FFFF);
      pad_in = 32'h3;
      repeat (2) @(negedge clk);
      chk("R7 not yet pending", {31'b0, irq}, 0);
      @(negedge clk);
      chk("R10 irq on rise", {31'b0, irq}, 1);
      rdchk("R7 rise pending", 12'h048, 32'h1);
      pad_in = 32'h1;
      repeat (4) @(negedge clk);
      rdchk("R7 fall pending", 12'h048, 32'h3);
      pad_in = 32'h4;
      repeat (4) @(negedge clk);
      rdchk("R7 unmasked edges ignored", 12'h048, 32'h3);
      wr(12'h048, 32'h0);
      rdchk("R8 pending write ignored", 12'h048, 32'h3);
      wr(12'h04C, 32'h1);
      rdchk("R8 single clear", 12'h048, 32'h2);
      chk("R10 irq still high", {31'b0, irq}, 1);
      wr(12'h04C, 32'hFFFF_FFFF);
      rdchk("R8 clear all", 12'h048, 32'h0);
      chk("R10 irq low", {31'b0, irq}, 0);
      repeat (4) @(negedge clk);
      rdchk("R7 steady level no event", 12'h048, 32'h0);
      rdchk("R11 read ack", 12'h04C, 0);
      wr(12'h040, 0); wr(12'h044, 0);
   endtask

   task automatic t_collide;
      pad_in = 32'h0;
      repeat (4) @(negedge clk);
      wr(12'h040, 32'h8000_0018);
      wr(12'h044, 32'h0000_0008);
      pad_in = 32'h8000_0018;
      repeat (4) @(negedge clk);
      rdchk("R7 bit31 pending", 12'h048, 32'h8000_0018);
      @(negedge clk); pad_in = 32'h8000_0010;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 12'h04C; bus_wdata = 32'h0000_0018;
      @(negedge clk); bus_sel = 0; bus_wr = 0;
      rdchk("R9 collision keeps bit", 12'h048, 32'h8000_0008);
      wr(12'h04C, 32'hFFFF_FFFF);
      wr(12'h040, 0); wr(12'h044, 0);
   endtask

   task automatic t_unmapped;
      wr(12'h010, 32'h0000_00C3);
      wr(12'h030, 32'hFFFF_FFFF);
      wr(12'h01C, 32'hFFFF_FFFF);
      wr(12'h800, 32'hFFFF_FFFF);
      rdchk("R11 unmapped read", 12'h030, 0);
      rdchk("R11 high unmapped read", 12'h800, 0);
      rdchk("R11 dir untouched", 12'h010, 32'h0000_00C3);
      rdchk("R11 rise_en untouched", 12'h040, 0);
      rdchk("R11 altsel untouched", 12'h020, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_value();
      t_dir();
      t_pull();
      t_alt();
      t_input();
      t_edges();
      t_collide();
      t_unmapped();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule